// File: doc/BRIEF.md
# Countdown Timer with Background Reload

This block is a down-counting timer driven through a small register write/read port. Software programs a reload value, picks periodic or one-shot operation and enables counting. Each time the count runs out, a sticky status bit is set. A single interrupt line reports that status bit, masked by an interrupt-enable bit. In periodic operation the counter refills itself from the reload register and keeps running without waiting for software. In one-shot operation it parks at zero until software restarts it.

The reload register can be written in two ways. A direct write replaces the live count at once. A background write changes only the reload register, so the new interval starts at the next terminal count. Software can therefore queue an interval of different length without disturbing the interval that is running. A change of mode made while the counter runs is taken into account only at the next terminal count.

Top module: `bgr_countdown_timer`

## Requirements
- R1: After reset, every readable register returns 0: control (address 0), reload (addresses 1 and 2), count (address 3) and status (address 4). The interrupt output is 0.
- R2: Control bit 0 enables counting. While it is 0, the count holds its value, apart from direct reload writes, which still prime the count.
- R3: With control bit 1 at 0 (periodic), the enabled count drops by one per cycle. A terminal count occurs when the count is 1, or when the count is 0 while enabled. A terminal count sets the status bit and refills the count from the reload register, so a reload value of N gives one terminal count every N cycles.
- R4: A write to address 1 stores the data in the reload register and loads it into the count at the same clock edge, overriding any decrement or terminal count in that cycle.
- R5: A write to address 2 stores the data in the reload register only. The count continues from its present value and picks up the new value at its next refill. A read of address 1 or 2 returns the reload register.
- R6: With control bit 1 at 1 (one-shot), a terminal count sets the status bit once, sets the count to 0 and stops counting. No further terminal count occurs while the counter is stopped.
- R7: A stopped one-shot counter restarts when address 1 is written with a non-zero value. A write of zero leaves it stopped.
- R8: Clearing control bit 1 while the one-shot counter is stopped refills the count from the reload register one cycle later. The counter then runs in periodic mode.
- R9: Changing control bit 1 while the counter runs does not change the count. The mode in force at the terminal count decides between refill and stop.
- R10: The status bit (address 4, bit 0) stays set until a write of 1 to that bit clears it. A terminal count while the bit is already set leaves it set, so that event is lost. If a clear and a terminal count fall in the same cycle, the bit ends up set.
- R11: The interrupt output equals the status bit ANDed with control bit 2 (interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register at reg_addr |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data of the register at reg_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two situations are the hardest to reach from the ports. The first is a status clear that lands in exactly the cycle of a terminal count. The second is a mode bit cleared while a one-shot counter is parked. The stimulus reaches both by loading a known count with a direct write and then counting clock edges. That places the status-clear write on the edge where the count is 1, and the control write on a cycle after the one-shot stop. The stimulus also switches the mode mid-count and issues background writes, then reads the count back to show that neither disturbed the running interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_LOAD   = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_BGLOAD = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_STAT   = 3'd4;

  localparam int CTRL_RUN     = 0;
  localparam int CTRL_ONESHOT = 1;
  localparam int CTRL_IRQEN   = 2;
  localparam int CTRL_BITS    = 3;

  localparam int STAT_EVT = 0;
endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  input  logic              zero_evt,
  output logic              run_en,
  output logic              oneshot,
  output logic              irq_en,
  output logic [W-1:0]      reload,
  output logic              status,
  output logic              load_wr,
  output logic              bg_wr,
  output logic              clr_wr
);

  logic ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
  assign load_wr = reg_wr && (reg_addr == ADR_LOAD);
  assign bg_wr   = reg_wr && (reg_addr == ADR_BGLOAD);
  assign clr_wr  = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[STAT_EVT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en  <= 1'b0;
      oneshot <= 1'b0;
      irq_en  <= 1'b0;
    end else if (ctrl_wr) begin
      run_en  <= reg_wdata[CTRL_RUN];
      oneshot <= reg_wdata[CTRL_ONESHOT];
      irq_en  <= reg_wdata[CTRL_IRQEN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '0;
    end else if (load_wr || bg_wr) begin
      reload <= reg_wdata;
    end
  end

  // A terminal count outranks a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
    end else if (zero_evt) begin
      status <= 1'b1;
    end else if (clr_wr) begin
      status <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic         oneshot,
  input  logic         load_wr,
  input  logic [W-1:0] load_data,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         halted,
  output logic         zero_evt,
  output logic         restart
);

  // Terminal when the count is 1 (about to reach zero) or already 0.
  function automatic logic is_terminal(input logic [W-1:0] v);
    return (v[W-1:1] == '0);
  endfunction

  // Value taken on a terminal count: refill in periodic mode, park at 0 in one-shot.
  function automatic logic [W-1:0] after_terminal(input logic os, input logic [W-1:0] rl);
    return os ? '0 : rl;
  endfunction

  assign zero_evt = run_en && !halted && !load_wr && is_terminal(cnt);
  assign restart  = halted && !oneshot && !load_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      halted <= 1'b0;
    end else if (load_wr) begin
      cnt <= load_data;
      if (load_data != '0) halted <= 1'b0;
    end else if (restart) begin
      cnt    <= reload_val;
      halted <= 1'b0;
    end else if (zero_evt) begin
      cnt    <= after_terminal(oneshot, reload_val);
      halted <= oneshot;
    end else if (run_en && !halted) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/bgr_countdown_timer.sv
module bgr_countdown_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);

  logic         run_en;
  logic         oneshot;
  logic         irq_en;
  logic [W-1:0] reload;
  logic         status;
  logic         load_wr;
  logic         bg_wr;
  logic         clr_wr;
  logic [W-1:0] cnt;
  logic         halted;
  logic         zero_evt;
  logic         restart;

  tmr_ctrl_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .zero_evt  (zero_evt),
    .run_en    (run_en),
    .oneshot   (oneshot),
    .irq_en    (irq_en),
    .reload    (reload),
    .status    (status),
    .load_wr   (load_wr),
    .bg_wr     (bg_wr),
    .clr_wr    (clr_wr)
  );

  tmr_down_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .oneshot    (oneshot),
    .load_wr    (load_wr),
    .load_data  (reg_wdata),
    .reload_val (reload),
    .cnt        (cnt),
    .halted     (halted),
    .zero_evt   (zero_evt),
    .restart    (restart)
  );

  assign irq = status && irq_en;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: begin
        reg_rdata[CTRL_RUN]     = run_en;
        reg_rdata[CTRL_ONESHOT] = oneshot;
        reg_rdata[CTRL_IRQEN]   = irq_en;
      end
      ADR_LOAD, ADR_BGLOAD: reg_rdata = reload;
      ADR_COUNT:            reg_rdata = cnt;
      ADR_STAT:             reg_rdata[STAT_EVT] = status;
      default:              reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] reg_wdata,
  input logic         run_en,
  input logic         oneshot,
  input logic         irq_en,
  input logic [W-1:0] reload,
  input logic         status,
  input logic         load_wr,
  input logic         bg_wr,
  input logic         clr_wr,
  input logic [W-1:0] cnt,
  input logic         halted,
  input logic         zero_evt,
  input logic         irq
);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !load_wr && !(halted && !oneshot)) |=> $stable(cnt)); // R2
  AST_PERIODIC_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && !oneshot) |=> (cnt == $past(reload))); // R3
  AST_LOAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt == $past(reg_wdata))); // R4
  AST_BG_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_wr && !run_en && !halted) |=> $stable(cnt)); // R5
  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_evt && oneshot) |=> (halted && (cnt == '0))); // R6
  AST_HALTED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (cnt == '0)); // R6
  AST_NONZERO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && (reg_wdata != '0)) |=> !halted); // R7
  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !oneshot && !load_wr) |=> (!halted && (cnt == $past(reload)))); // R8
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr_wr) |=> status); // R10
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> status); // R10
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status); // R11
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq); // R11

endmodule

bind bgr_countdown_timer tmr_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wdata (reg_wdata),
  .run_en    (run_en),
  .oneshot   (oneshot),
  .irq_en    (irq_en),
  .reload    (reload),
  .status    (status),
  .load_wr   (load_wr),
  .bg_wr     (bg_wr),
  .clr_wr    (clr_wr),
  .cnt       (cnt),
  .halted    (halted),
  .zero_evt  (zero_evt),
  .irq       (irq)
);

// File: tb/bgr_countdown_timer_bench.sv
`timescale 1ns/1ps
module bgr_countdown_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_wr = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bgr_countdown_timer #(.W(W)) u_bgr_countdown_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // kind 0: write addr<=data for one cycle; kind 1: let data cycles pass.
  // Afterwards read raddr and compare with exp and the irq output.
  typedef struct packed {
    logic         kind;
    logic [2:0]   addr;
    logic [15:0]  data;
    logic [2:0]   raddr;
    logic [15:0]  exp;
    logic         xirq;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd1, 16'd5,  3'd3, 16'd5,  1'b0, 8'd2},  // R2 load primes while off
    '{1'b1, 3'd0, 16'd3,  3'd3, 16'd5,  1'b0, 8'd2},  // R2 holds while off
    '{1'b0, 3'd0, 16'd5,  3'd3, 16'd5,  1'b0, 8'd3},  // R3 enable periodic
    '{1'b1, 3'd0, 16'd4,  3'd3, 16'd1,  1'b0, 8'd3},  // R3 counts down
    '{1'b1, 3'd0, 16'd1,  3'd4, 16'd1,  1'b1, 8'd3},  // R3 terminal count
    '{1'b1, 3'd0, 16'd5,  3'd3, 16'd5,  1'b1, 8'd10}, // R10 second event lost
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10}, // R10 clear
    '{1'b0, 3'd2, 16'd9,  3'd3, 16'd3,  1'b0, 8'd5},  // R5 count untouched
    '{1'b1, 3'd0, 16'd0,  3'd1, 16'd9,  1'b0, 8'd5},  // R5 reload updated
    '{1'b1, 3'd0, 16'd2,  3'd3, 16'd1,  1'b0, 8'd5},
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd9,  1'b1, 8'd5},  // R5 new value at refill
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10},
    '{1'b0, 3'd1, 16'd20, 3'd3, 16'd20, 1'b0, 8'd4},  // R4 immediate load
    '{1'b0, 3'd0, 16'd7,  3'd3, 16'd19, 1'b0, 8'd9},  // R9 to one-shot mid count
    '{1'b0, 3'd0, 16'd5,  3'd3, 16'd18, 1'b0, 8'd9},  // R9 back to periodic
    '{1'b1, 3'd0, 16'd17, 3'd3, 16'd1,  1'b0, 8'd9},
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd20, 1'b1, 8'd9},  // R9 refilled
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10},
    '{1'b0, 3'd0, 16'd7,  3'd3, 16'd18, 1'b0, 8'd6},  // R6 one-shot
    '{1'b1, 3'd0, 16'd17, 3'd3, 16'd1,  1'b0, 8'd6},
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd0,  1'b1, 8'd6},  // R6 parks at 0
    '{1'b1, 3'd0, 16'd4,  3'd4, 16'd1,  1'b1, 8'd6},
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10},
    '{1'b1, 3'd0, 16'd3,  3'd4, 16'd0,  1'b0, 8'd6},  // R6 no second event
    '{1'b0, 3'd1, 16'd0,  3'd3, 16'd0,  1'b0, 8'd7},  // R7 zero write
    '{1'b1, 3'd0, 16'd2,  3'd4, 16'd0,  1'b0, 8'd7},  // R7 stays stopped
    '{1'b0, 3'd1, 16'd4,  3'd3, 16'd4,  1'b0, 8'd7},  // R7 non-zero restarts
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd3,  1'b0, 8'd7},
    '{1'b1, 3'd0, 16'd3,  3'd4, 16'd1,  1'b1, 8'd6},
    '{1'b0, 3'd0, 16'd5,  3'd3, 16'd0,  1'b1, 8'd8},  // R8 mode cleared while stopped
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd4,  1'b1, 8'd8},  // R8 refilled
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd3,  1'b1, 8'd8},  // R8 runs periodic
    '{1'b0, 3'd0, 16'd1,  3'd4, 16'd1,  1'b0, 8'd11}, // R11 masked
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10},
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd1,  1'b0, 8'd10}, // R10 set beats clear
    '{1'b0, 3'd0, 16'd0,  3'd3, 16'd3,  1'b0, 8'd2},
    '{1'b1, 3'd0, 16'd3,  3'd3, 16'd3,  1'b0, 8'd2},  // R2 disabled hold
    '{1'b0, 3'd1, 16'd0,  3'd3, 16'd0,  1'b0, 8'd4},
    '{1'b0, 3'd4, 16'd1,  3'd4, 16'd0,  1'b0, 8'd10},
    '{1'b0, 3'd0, 16'd5,  3'd0, 16'd5,  1'b0, 8'd1},  // R1 control readback
    '{1'b1, 3'd0, 16'd1,  3'd4, 16'd1,  1'b1, 8'd3},  // R3 enabled at 0
    '{1'b1, 3'd0, 16'd1,  3'd3, 16'd0,  1'b1, 8'd3}   // R3 reload 0 stays 0
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    reg_addr = a;
    #0.5;
    check(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    read_chk("R1 ctrl", 3'd0, '0);
    read_chk("R1 load", 3'd1, '0);
    read_chk("R1 count", 3'd3, '0);
    read_chk("R1 status", 3'd4, '0);
    check("R1 irq", {15'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].kind == 1'b0) begin
        reg_addr  = TBL[i].addr;
        reg_wdata = TBL[i].data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
      end else begin
        for (int k = 0; k < int'(TBL[i].data); k++) @(negedge clk);
      end
      read_chk($sformatf("R%0d vec %0d rdata", TBL[i].req, i), TBL[i].raddr, TBL[i].exp);
      check($sformatf("R%0d vec %0d irq", TBL[i].req, i), {15'd0, irq}, {15'd0, TBL[i].xirq});
    end

    // R1 reset in the middle of operation
    rst_n = 1'b0;
    @(negedge clk);
    read_chk("R1 ctrl after reset", 3'd0, '0);
    read_chk("R1 count after reset", 3'd3, '0);
    read_chk("R1 status after reset", 3'd4, '0);
    check("R1 irq after reset", {15'd0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

endmodule